// File: doc/BRIEF.md
# Synchronous Serial Port (Master and Slave)

This block moves one 8-bit word at a time over a three-wire synchronous serial link with an optional active-low select line. A small register bus gives access to three locations: a data buffer, a control register and a status register. Writing the buffer loads the word to send. Reading it returns the last word received. As master, the block drives the serial clock, derived from the system clock or from pulses of a timer. As slave, it follows a serial clock coming in on a pin, and that clock can be gated by the select line.

Each word is shifted MSB first. One control bit sets the idle level of the clock and, with it, which edge is used for what. The edge that leaves the idle level moves the next bit out. The edge that returns to the idle level samples the incoming bit. At the end of every word the block raises a completion flag, which also drives the interrupt line. It also marks the receive buffer as full. Two error bits record a word that arrives while the buffer is still full and a buffer write made while a word is still shifting.

Register map, with byte address on `bus_addr`:
- 0 is the data buffer.
- 1 is control: bit 7 enable, bit 6 clock idle level, bit 5 overflow, bit 4 write collision, bits 3..0 mode.
- 2 is status: bit 0 receive full, bit 1 word done.

Top module: `ssp_port`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x00, and `sck_oe`, `sdo_oe` and `irq` are 0.
- R2: While control bit 7 (enable) is 0, `sck_oe`, `sdo_oe` and `port_en` are 0. A buffer write starts nothing, and status stays 0.
- R3: In a master mode (mode bits 3..2 = 00), a buffer write while idle starts one 8-bit transfer. `sdo` carries the written word MSB first, and the word sampled on `sdi` appears at buffer address 0.
- R4: The master clock half-period is 2 system clocks in mode 0000, 8 in mode 0001 and 32 in mode 0010. In mode 0011, SCK toggles once per `tmr_tick` pulse, so its rate is half the timer rate.
- R5: With control bit 6 = 0, SCK idles low, `sdo` changes on the rising edge and `sdi` is sampled on the falling edge. With bit 6 = 1, the idle level and the edges are inverted.
- R6: Completing a word sets status bit 1 and `irq`. Writing status with bit 1 = 1 clears both.
- R7: Completing a word sets status bit 0. Reading address 0 clears it.
- R8: If a word completes while status bit 0 is set, control bit 5 (overflow) is set and the buffer keeps its old contents.
- R9: A buffer write during a transfer sets control bit 4 (collision) and leaves the word being shifted unchanged.
- R10: Mode 0101 is a slave clocked by `sck_in` that ignores `ss_n`. It shifts out the buffered word and receives a word on `sdi`.
- R11: In mode 0100, `ss_n` high releases `sdo` (`sdo_oe` = 0), blocks shifting and resets the bit counter. `ss_n` low enables the slave.
- R12: Mode codes 0110 to 1111 behave as off: no clock edges, both pins released, and no transfer.
- R13: A control write with bit 5 or bit 4 = 0 clears that flag. Writing 1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| tmr_tick | input | 1 | One-cycle timer pulse used by mode 0011 |
| sck_in | input | 1 | Serial clock from pin (slave) |
| sck_out | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Clock pin output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data-out pin enable |
| ss_n | input | 1 | Active-low slave select |
| port_en | output | 1 | Serial function owns the pins |
| irq | output | 1 | Word-done interrupt |

## Verification
A wrong bit counter shows up quickly at the ports. Completion arrives after the wrong number of SCK edges, or too early after a deselect, so status bit 1 is wrong immediately after the last sampling edge. If the shift registers are off by one, `sdo` shows a rotated word at the leading edges, and the buffer read right after completion shows a rotated word too. Errors in the flag logic appear in the control or status readback in the cycle after the event that caused them.

// File: rtl/ssp_pkg.sv
// Shared definitions for the synchronous serial port: register addresses,
// mode codes and the packed control register layout.
package ssp_pkg;

    localparam logic [1:0] ADDR_BUF = 2'd0;
    localparam logic [1:0] ADDR_CTL = 2'd1;
    localparam logic [1:0] ADDR_STA = 2'd2;

    localparam logic [3:0] MODE_MST_D4   = 4'b0000;
    localparam logic [3:0] MODE_MST_D16  = 4'b0001;
    localparam logic [3:0] MODE_MST_D64  = 4'b0010;
    localparam logic [3:0] MODE_MST_TMR  = 4'b0011;
    localparam logic [3:0] MODE_SLV_GATE = 4'b0100;
    localparam logic [3:0] MODE_SLV_FREE = 4'b0101;

    // Control register, bit 7 down to bit 0
    typedef struct packed {
        logic       en;
        logic       cpol;
        logic       ovf;
        logic       wcol;
        logic [3:0] mode;
    } ctl_t;

endpackage

// File: rtl/ssp_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes STAGES >= 2; all bits reset to 0.
module ssp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // shift pin values through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ssp_baud.sv
// Master clock tick generator. Produces one tick per SCK half-period:
// HALF_BASE << (STEP_LOG2*sel) system clocks for sel 0..2, or one tick per
// timer pulse for sel 3. Counter holds at zero while run is low, so the
// first tick comes one full half-period after a start.
module ssp_baud #(
    parameter int HALF_BASE = 2,
    parameter int STEP_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       tmr_tick,
    output logic       tick
);
    localparam int MAX_HALF = HALF_BASE << (2 * STEP_LOG2);
    localparam int CW       = $clog2(MAX_HALF);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // select the terminal count for the chosen divider
    always_comb begin
        case (sel)
            2'd0:    lim = CW'(HALF_BASE - 1);
            2'd1:    lim = CW'((HALF_BASE << STEP_LOG2) - 1);
            default: lim = CW'(MAX_HALF - 1);
        endcase
    end

    // count system clocks within a half-period
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (!run || sel == 2'd3)    cnt <= '0;
        else if (cnt == lim)             cnt <= '0;
        else                             cnt <= cnt + 1'b1;
    end

    assign tick = run && ((sel == 2'd3) ? tmr_tick : (cnt == lim));
endmodule

// File: rtl/ssp_engine.sv
// Shift engine shared by master and slave roles. Leading edge (away from the
// idle level) shifts the next bit out; trailing edge samples the input bit.
// Assumes slave inputs arrive already synchronized and W is a power of two.
module ssp_engine #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 is_mst,
    input  logic                 is_slv,
    input  logic                 gated,
    input  logic                 cpol,
    input  logic                 load,
    input  logic [W-1:0]         load_data,
    input  logic                 tick,
    input  logic                 sck_s,
    input  logic                 ss_s,
    input  logic                 sdi_raw,
    input  logic                 sdi_s,
    output logic                 busy,
    output logic                 sck_q,
    output logic                 sdo_q,
    output logic                 slv_sel,
    output logic                 done,
    output logic [W-1:0]         rx_word,
    output logic [$clog2(W)-1:0] bit_cnt
);
    localparam int CNTW = $clog2(W);

    logic [W-1:0] tx_sr;
    logic [W-1:0] rx_sr;
    logic         sck_prev;
    logic         m_tick, lead, trail, smp, abort;

    // decode edges for either role and pick the sampling source
    always_comb begin
        slv_sel = is_slv && (!gated || !ss_s);
        m_tick  = is_mst && busy && tick;
        lead    = (m_tick && (sck_q == cpol)) ||
                  (slv_sel && (sck_prev == cpol) && (sck_s != cpol));
        trail   = (m_tick && (sck_q != cpol)) ||
                  (slv_sel && (sck_prev != cpol) && (sck_s == cpol));
        smp     = is_mst ? sdi_raw : sdi_s;
        abort   = !(is_mst || slv_sel);
        done    = trail && (bit_cnt == CNTW'(W - 1));
        rx_word = {rx_sr[W-2:0], smp};
    end

    // transfer state: busy flag and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
        end else if (abort) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
        end else if (load && is_mst) begin
            busy    <= 1'b1;
            bit_cnt <= '0;
        end else begin
            if (lead) busy <= 1'b1;
            if (trail) bit_cnt <= done ? '0 : bit_cnt + 1'b1;
            if (done) busy <= 1'b0;
        end
    end

    // data path: transmit shifter, receive shifter, output bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (load)      tx_sr <= load_data;
            else if (lead) tx_sr <= {tx_sr[W-2:0], 1'b0};
            if (lead)      sdo_q <= tx_sr[W-1];
            if (trail)     rx_sr <= rx_word;
        end
    end

    // master clock level and slave clock history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_s;
            if (!(is_mst && busy)) sck_q <= cpol;
            else if (tick)         sck_q <= ~sck_q;
        end
    end
endmodule

// File: rtl/ssp_regfile.sv
// Register bus side: control register, receive buffer, status flags.
// Assumes W >= 8; bus reads are combinational, read side effect only on the
// buffer address. Flag sets win over simultaneous clears.
module ssp_regfile
    import ssp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   addr,
    input  logic         wr,
    input  logic         rd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         busy,
    input  logic         done,
    input  logic [W-1:0] rx_word,
    output ctl_t         ctl,
    output logic         load,
    output logic [W-1:0] load_data,
    output logic         rx_full,
    output logic         done_flag
);
    logic [W-1:0] rx_buf;
    logic wr_buf, wr_ctl, wr_sta, rd_buf, valid_mode, coll, ovf_set;

    // decode bus strobes and events
    always_comb begin
        wr_buf     = wr && (addr == ADDR_BUF);
        wr_ctl     = wr && (addr == ADDR_CTL);
        wr_sta     = wr && (addr == ADDR_STA);
        rd_buf     = rd && (addr == ADDR_BUF);
        valid_mode = (ctl.mode[3:2] == 2'b00) || (ctl.mode == MODE_SLV_GATE) ||
                     (ctl.mode == MODE_SLV_FREE);
        load       = wr_buf && ctl.en && valid_mode && !busy;
        coll       = wr_buf && ctl.en && busy;
        ovf_set    = done && rx_full;
        load_data  = wdata;
    end

    // control register with sticky error bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_ctl) begin
            ctl.en   <= wdata[7];
            ctl.cpol <= wdata[6];
            ctl.ovf  <= ovf_set | (ctl.ovf & wdata[5]);
            ctl.wcol <= coll | (ctl.wcol & wdata[4]);
            ctl.mode <= wdata[3:0];
        end else begin
            ctl.ovf  <= ctl.ovf | ovf_set;
            ctl.wcol <= ctl.wcol | coll;
        end
    end

    // receive buffer and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf    <= '0;
            rx_full   <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            if (done && !rx_full) rx_buf <= rx_word;
            rx_full   <= done ? 1'b1 : (rd_buf ? 1'b0 : rx_full);
            done_flag <= done ? 1'b1 : ((wr_sta && wdata[1]) ? 1'b0 : done_flag);
        end
    end

    // read multiplexer
    always_comb begin
        case (addr)
            ADDR_BUF: rdata = rx_buf;
            ADDR_CTL: rdata = W'(ctl);
            ADDR_STA: rdata = W'({done_flag, rx_full});
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ssp_port.sv
// Top of the synchronous serial port: synchronizes pin inputs, generates the
// master clock, runs the shift engine and exposes the register bus.
// Assumes a single clock domain for the bus; sck_in, ss_n and sdi may be
// asynchronous (slave use). Master sampling uses sdi directly.
module ssp_port
    import ssp_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int HALF_BASE = 2,
    parameter int STEP_LOG2 = 2,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tmr_tick,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              ss_n,
    output logic              port_en,
    output logic              irq
);
    localparam int CNTW = $clog2(DATA_W);

    ctl_t              ctl;
    logic [2:0]        pins_s;
    logic              sck_s, ss_s, sdi_s;
    logic              ctl_en, ctl_cpol, ctl_ovf, ctl_wcol;
    logic              is_mst, is_slv, gated, gated_desel;
    logic              load, busy, tick, done_evt, rx_full, done_flag;
    logic              sck_q, sdo_q, slv_sel;
    logic [DATA_W-1:0] load_data, rx_word;
    logic [CNTW-1:0]   bit_cnt;

    ssp_sync #(.WIDTH(3), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_in, ss_n, sdi}),
        .q     (pins_s)
    );

    // role decode from the control register
    always_comb begin
        sck_s       = pins_s[2];
        ss_s        = pins_s[1];
        sdi_s       = pins_s[0];
        ctl_en      = ctl.en;
        ctl_cpol    = ctl.cpol;
        ctl_ovf     = ctl.ovf;
        ctl_wcol    = ctl.wcol;
        is_mst      = ctl.en && (ctl.mode[3:2] == 2'b00);
        is_slv      = ctl.en && ((ctl.mode == MODE_SLV_GATE) || (ctl.mode == MODE_SLV_FREE));
        gated       = (ctl.mode == MODE_SLV_GATE);
        gated_desel = ctl.en && gated && ss_s;
    end

    ssp_baud #(.HALF_BASE(HALF_BASE), .STEP_LOG2(STEP_LOG2)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (is_mst && busy),
        .sel      (ctl.mode[1:0]),
        .tmr_tick (tmr_tick),
        .tick     (tick)
    );

    ssp_engine #(.W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_mst    (is_mst),
        .is_slv    (is_slv),
        .gated     (gated),
        .cpol      (ctl.cpol),
        .load      (load),
        .load_data (load_data),
        .tick      (tick),
        .sck_s     (sck_s),
        .ss_s      (ss_s),
        .sdi_raw   (sdi),
        .sdi_s     (sdi_s),
        .busy      (busy),
        .sck_q     (sck_q),
        .sdo_q     (sdo_q),
        .slv_sel   (slv_sel),
        .done      (done_evt),
        .rx_word   (rx_word),
        .bit_cnt   (bit_cnt)
    );

    ssp_regfile #(.W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .busy      (busy),
        .done      (done_evt),
        .rx_word   (rx_word),
        .ctl       (ctl),
        .load      (load),
        .load_data (load_data),
        .rx_full   (rx_full),
        .done_flag (done_flag)
    );

    // pin ownership and outputs
    always_comb begin
        sck_out = sck_q;
        sck_oe  = is_mst;
        sdo     = sdo_q;
        sdo_oe  = is_mst || slv_sel;
        port_en = ctl.en;
        irq     = done_flag;
    end
endmodule

// File: rtl/ssp_port_chk.sv
// Property checker for ssp_port, attached by bind below.
module ssp_port_chk #(
    parameter int W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctl_en,
    input logic                 is_mst,
    input logic                 ctl_cpol,
    input logic                 busy,
    input logic                 sck_out,
    input logic                 sck_oe,
    input logic                 sdo_oe,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [1:0]           bus_addr,
    input logic                 ctl_wcol,
    input logic                 ctl_ovf,
    input logic                 rx_full,
    input logic                 done_evt,
    input logic                 irq,
    input logic                 gated_desel,
    input logic [$clog2(W)-1:0] bit_cnt
);
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> (!sck_oe && !sdo_oe && !busy));

    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mst && $past(is_mst) && !busy && !$past(busy) && $stable(ctl_cpol))
        |-> (sck_out == ctl_cpol));

    a_r6_done_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (irq && rx_full));

    a_r7_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0 && !done_evt) |=> !rx_full);

    a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_ovf) |-> $past(done_evt && rx_full));

    a_r9_wcol_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_wcol) |-> $past(bus_wr && bus_addr == 2'd0 && busy));

    a_r11_deselect_resets: assert property (@(posedge clk) disable iff (!rst_n)
        gated_desel |=> (bit_cnt == '0 && !busy));
endmodule

bind ssp_port ssp_port_chk #(.W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_en      (ctl_en),
    .is_mst      (is_mst),
    .ctl_cpol    (ctl_cpol),
    .busy        (busy),
    .sck_out     (sck_out),
    .sck_oe      (sck_oe),
    .sdo_oe      (sdo_oe),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .ctl_wcol    (ctl_wcol),
    .ctl_ovf     (ctl_ovf),
    .rx_full     (rx_full),
    .done_evt    (done_evt),
    .irq         (irq),
    .gated_desel (gated_desel),
    .bit_cnt     (bit_cnt)
);

// File: tb/ssp_port_tb.sv
module ssp_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tmr_tick = 1'b0;
    logic       sck_in = 1'b0;
    logic       sck_out, sck_oe, sdo, sdo_oe, port_en, irq;
    logic       sdi = 1'b0;
    logic       ss_n = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    logic cur_cks = 1'b0;
    logic [7:0] slv_seen;

    always #4 clk = ~clk;

    ssp_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_tick(tmr_tick), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n), .port_en(port_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic read_buf(output logic [7:0] d);
        @(negedge clk);
        bus_addr = 2'd0; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // watch master SCK edges, act as remote slave, optionally collide
    task automatic run_master(input int half_exp, input bit use_tmr, input logic [7:0] slv,
                              input int coll_at, input logic [7:0] coll_d,
                              output logic [7:0] seen, output int bad_gap, output int edges);
        logic prev;
        int last_t;
        int leads;
        prev = sck_out; last_t = -1; edges = 0; leads = 0; seen = 8'h00; bad_gap = 0;
        for (int cyc = 0; cyc < 3000 && edges < 16; cyc++) begin
            @(negedge clk);
            bus_wr = (cyc == coll_at);
            if (cyc == coll_at) begin bus_addr = 2'd0; bus_wdata = coll_d; end
            tmr_tick = use_tmr && (cyc % 3 == 2);
            if (sck_out !== prev) begin
                if (last_t >= 0 && (cyc - last_t) != half_exp) bad_gap++;
                last_t = cyc;
                if (prev == cur_cks) begin
                    seen = {seen[6:0], sdo};
                    if (leads < 8) sdi = slv[7 - leads];
                    leads++;
                end
                prev = sck_out;
                edges++;
            end
        end
        @(negedge clk);
        bus_wr = 1'b0; tmr_tick = 1'b0;
    endtask

    task automatic master_xfer(input logic [3:0] mode, input logic cks, input logic [7:0] tx,
                               input logic [7:0] slv, input int half, input bit use_tmr,
                               input bit consume, input string req);
        logic [7:0] seen, d;
        int bad, edges;
        cur_cks = cks;
        bus_write(2'd1, {1'b1, cks, 2'b00, mode});
        bus_write(2'd0, tx);
        run_master(half, use_tmr, slv, -1, 8'h00, seen, bad, edges);
        chk({req, " R3 sdo word MSB first"}, {24'h0, seen}, {24'h0, tx});
        chk({req, " R4 half-period spacing errors"}, bad, 0);
        chk({req, " R3 sixteen SCK edges"}, edges, 16);
        chk({req, " R5 SCK idle level"}, {31'h0, sck_out}, {31'h0, cks});
        if (consume) begin
            peek(2'd2, d);
            chk({req, " R6 R7 status after word"}, {24'h0, d}, 32'h3);
            chk({req, " R6 irq raised"}, {31'h0, irq}, 32'h1);
            read_buf(d);
            chk({req, " R3 received word"}, {24'h0, d}, {24'h0, slv});
            peek(2'd2, d);
            chk({req, " R7 full cleared by read"}, {24'h0, d}, 32'h2);
            bus_write(2'd2, 8'h02);
            peek(2'd2, d);
            chk({req, " R6 done cleared"}, {24'h0, d}, 32'h0);
            chk({req, " R6 irq cleared"}, {31'h0, irq}, 32'h0);
        end
    endtask

    // remote master driving sck_in; bits first..first+n-1 of mst
    task automatic slave_bits(input int first, input int n, input logic [7:0] mst);
        for (int i = first; i < first + n; i++) begin
            @(negedge clk);
            sck_in = ~cur_cks;
            sdi = mst[7 - i];
            repeat (6) @(negedge clk);
            slv_seen = {slv_seen[6:0], sdo};
            sck_in = cur_cks;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(2'd1, d);
        chk("R1 control reset", {24'h0, d}, 32'h0);
        peek(2'd2, d);
        chk("R1 status reset", {24'h0, d}, 32'h0);
        chk("R1 pins released", {30'h0, sck_oe, sdo_oe}, 32'h0);
        chk("R1 irq low", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        logic s0;
        bus_write(2'd1, 8'h00);
        s0 = sck_out;
        bus_write(2'd0, 8'hA5);
        repeat (30) @(negedge clk);
        chk("R2 pins released while off", {29'h0, sck_oe, sdo_oe, port_en}, 32'h0);
        chk("R2 SCK quiet while off", {31'h0, sck_out}, {31'h0, s0});
        peek(2'd2, d);
        chk("R2 no completion while off", {24'h0, d}, 32'h0);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        int toggles;
        logic s0;
        bus_write(2'd1, 8'h86);
        s0 = sck_out; toggles = 0;
        bus_write(2'd0, 8'h55);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sck_out !== s0) toggles++;
        end
        chk("R12 no SCK in reserved mode", toggles, 0);
        chk("R12 pins released", {30'h0, sck_oe, sdo_oe}, 32'h0);
        peek(2'd2, d);
        chk("R12 no completion", {24'h0, d}, 32'h0);
    endtask

    task automatic t_overflow();
        logic [7:0] d, seen;
        int bad, edges;
        master_xfer(4'b0000, 1'b0, 8'h11, 8'h5A, 2, 1'b0, 1'b0, "ovf first");
        bus_write(2'd0, 8'h22);
        run_master(2, 1'b0, 8'hC3, -1, 8'h00, seen, bad, edges);
        repeat (2) @(negedge clk);
        peek(2'd1, d);
        chk("R8 overflow bit set", {24'h0, d}, 32'hA0);
        read_buf(d);
        chk("R8 old word kept", {24'h0, d}, 32'h5A);
        bus_write(2'd1, 8'hA0);
        peek(2'd1, d);
        chk("R13 overflow kept by writing 1", {24'h0, d}, 32'hA0);
        bus_write(2'd1, 8'h80);
        peek(2'd1, d);
        chk("R13 overflow cleared by writing 0", {24'h0, d}, 32'h80);
        bus_write(2'd2, 8'h02);
    endtask

    task automatic t_collision();
        logic [7:0] d, seen;
        int bad, edges;
        cur_cks = 1'b0;
        bus_write(2'd1, 8'h80);
        bus_write(2'd0, 8'h81);
        run_master(2, 1'b0, 8'h0F, 5, 8'h7E, seen, bad, edges);
        chk("R9 shifted word unchanged", {24'h0, seen}, 32'h81);
        peek(2'd1, d);
        chk("R9 collision bit set", {24'h0, d}, 32'h90);
        bus_write(2'd1, 8'h90);
        peek(2'd1, d);
        chk("R13 collision kept by writing 1", {24'h0, d}, 32'h90);
        bus_write(2'd1, 8'h80);
        peek(2'd1, d);
        chk("R13 collision cleared by writing 0", {24'h0, d}, 32'h80);
        read_buf(d);
        chk("R9 received word", {24'h0, d}, 32'h0F);
        bus_write(2'd2, 8'h02);
    endtask

    task automatic t_slave_free();
        logic [7:0] d;
        cur_cks = 1'b1;
        sck_in = 1'b1; ss_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_write(2'd1, 8'hC5);
        bus_write(2'd0, 8'hA5);
        slv_seen = 8'h00;
        slave_bits(0, 8, 8'h3C);
        repeat (6) @(negedge clk);
        chk("R10 slave sends buffered word", {24'h0, slv_seen}, 32'hA5);
        chk("R10 sdo driven with ss_n high", {31'h0, sdo_oe}, 32'h1);
        peek(2'd2, d);
        chk("R10 completion", {24'h0, d}, 32'h3);
        read_buf(d);
        chk("R10 slave received word", {24'h0, d}, 32'h3C);
        bus_write(2'd2, 8'h02);
    endtask

    task automatic t_slave_gated();
        logic [7:0] d;
        cur_cks = 1'b0;
        sck_in = 1'b0; ss_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_write(2'd1, 8'h84);
        bus_write(2'd0, 8'h96);
        chk("R11 sdo released when deselected", {31'h0, sdo_oe}, 32'h0);
        slave_bits(0, 8, 8'hFF);
        repeat (6) @(negedge clk);
        peek(2'd2, d);
        chk("R11 no shifting when deselected", {24'h0, d}, 32'h0);
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 sdo driven when selected", {31'h0, sdo_oe}, 32'h1);
        slave_bits(0, 3, 8'h00);
        ss_n = 1'b1;
        repeat (4) @(negedge clk);
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_write(2'd0, 8'h96);
        slv_seen = 8'h00;
        slave_bits(0, 5, 8'hC6);
        repeat (6) @(negedge clk);
        peek(2'd2, d);
        chk("R11 counter restarted after deselect", {24'h0, d}, 32'h0);
        slave_bits(5, 3, 8'hC6);
        repeat (6) @(negedge clk);
        peek(2'd2, d);
        chk("R11 completion after eight bits", {24'h0, d}, 32'h3);
        chk("R11 slave sends buffered word", {24'h0, slv_seen}, 32'h96);
        read_buf(d);
        chk("R11 slave received word", {24'h0, d}, 32'hC6);
        bus_write(2'd2, 8'h02);
        ss_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        master_xfer(4'b0000, 1'b0, 8'hB4, 8'h69, 2, 1'b0, 1'b1, "R4 div4");
        master_xfer(4'b0001, 1'b0, 8'h3C, 8'hA1, 8, 1'b0, 1'b1, "R4 div16");
        master_xfer(4'b0010, 1'b0, 8'h81, 8'h7E, 32, 1'b0, 1'b1, "R4 div64");
        master_xfer(4'b0011, 1'b0, 8'hE2, 8'h1D, 3, 1'b1, 1'b1, "R4 timer");
        master_xfer(4'b0000, 1'b1, 8'h5C, 8'hC3, 2, 1'b0, 1'b1, "R5 idle high");
        t_overflow();
        t_collision();
        t_reserved();
        t_slave_free();
        t_slave_gated();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end
endmodule